// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog for a system-on-chip. A 32-bit up-counter advances on a slow-clock tick. The tick arrives as a one-cycle pulse in the bus clock domain. It can be divided by a power of two before it reaches the counter. When the counter wraps past all ones while the timer runs, the block raises a one-cycle reset request and reloads the counter from the load register. To arm the timer for a timeout of N seconds at a 32768 Hz tick, software writes 2^32 − N·32768/2^e into the load register. It then refreshes the counter by writing a trigger word that differs from the previous one, usually its bitwise complement.

Running and stopping are guarded by two-word key sequences written to one register, so a single stray store cannot change the run state. Writes to the control, load, trigger and key registers are posted. Each of these registers has its own pending bit, which stays set for a fixed number of slow ticks. The write takes effect on the edge where that bit clears, which models the crossing into the slow domain.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the counter reads 0, the timer is stopped, all pending bits are 0, `rst_req` is low, the auto-idle bit reads 0 and the last stored trigger word is 0.
- R2: Reads decode as follows. 0x00 returns the REVISION parameter and 0x14 returns 1. 0x10 returns bit 0 as last written, and that write is immediate. 0x24 returns the committed control bits in place. 0x28 returns the counter, 0x2C the committed load value, 0x30 the last trigger word and 0x34 the pending bits.
- R3: A write to control (0x24), load (0x2C), trigger (0x30) or key (0x48) sets pending bit 0, 2, 3 or 4 of 0x34 respectively. The bit stays set for PEND_TICKS slow ticks, and the write takes effect on the edge where the bit clears.
- R4: A write to a posted register whose pending bit is still set is dropped.
- R5: Committed key words 0xBBBB followed directly by 0x4444 start the timer.
- R6: Committed key words 0xAAAA followed directly by 0x5555 stop the timer.
- R7: Any other key word, including a second word that does not match the first, returns the key sequencer to idle and leaves the run state unchanged.
- R8: A committed trigger word that differs from the stored one reloads the counter from the load register and is stored. An equal word has no effect.
- R9: While running, the counter rises by one on each count tick. While stopped, it holds its value.
- R10: Control bit 5 enables the prescaler and bits 4:2 hold an exponent e. When enabled, a count tick occurs on every 2^e-th slow tick. The divider restarts on a control commit and on a start, and when the prescaler is disabled every slow tick counts.
- R11: A count tick at 0xFFFFFFFF while running reloads the counter from the load register and drives `rst_req` high for exactly one clock. No request is raised while the timer is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bench goes after the key sequencer with sequences whose second word is broken. A sequencer that remembered a half-finished key across a bad word would start or stop the timer by mistake there. It writes the same trigger word twice; a design that reloads on every trigger write would jump the counter back. It checks the pending bits after each slow tick and writes twice into a busy slot. A design that committed early, or let the second write overwrite the first, shows the wrong load value. The bench also counts ticks across the wrap at all ones and under a divide-by-four prescale. An off-by-one there would move the reset request or the count by one tick, or make the request last more than one cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   localparam logic [7:0] A_REV   = 8'h00;
   localparam logic [7:0] A_SYS   = 8'h10;
   localparam logic [7:0] A_STAT  = 8'h14;
   localparam logic [7:0] A_CTRL  = 8'h24;
   localparam logic [7:0] A_CNT   = 8'h28;
   localparam logic [7:0] A_LOAD  = 8'h2C;
   localparam logic [7:0] A_TRIG  = 8'h30;
   localparam logic [7:0] A_PEND  = 8'h34;
   localparam logic [7:0] A_KEY   = 8'h48;

   localparam logic [31:0] KEY_RUN1  = 32'h0000_BBBB;
   localparam logic [31:0] KEY_RUN2  = 32'h0000_4444;
   localparam logic [31:0] KEY_HALT1 = 32'h0000_AAAA;
   localparam logic [31:0] KEY_HALT2 = 32'h0000_5555;

   // posted slot indices and the pending bit each one drives
   localparam int N_SLOTS = 4;
   localparam int S_CTRL = 0;
   localparam int S_LOAD = 1;
   localparam int S_TRIG = 2;
   localparam int S_KEY  = 3;

   typedef enum logic [1:0] {
      KS_IDLE,
      KS_RUN_ARMED,
      KS_HALT_ARMED
   } key_state_t;
endpackage

// File: rtl/wdt_posted.sv
module wdt_posted #(
   parameter int DW         = 32,
   parameter int PEND_TICKS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          slow_tick,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   output logic          busy,
   output logic          commit,
   output logic [DW-1:0] cdata
);
   localparam int CW = $clog2(PEND_TICKS + 1);
   localparam logic [CW-1:0] LAST = CW'(PEND_TICKS - 1);

   if (PEND_TICKS < 1) begin : g_bad_pend
      $error("wdt_posted: PEND_TICKS must be at least 1");
   end

   logic [CW-1:0] ticks_q;

   assign commit = busy && slow_tick && (ticks_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         ticks_q <= '0;
         cdata   <= '0;
      end else if (!busy) begin
         if (wr) begin
            busy    <= 1'b1;
            ticks_q <= '0;
            cdata   <= wdata;
         end
      end else if (slow_tick) begin
         if (ticks_q == LAST) busy <= 1'b0;
         else                 ticks_q <= ticks_q + 1'b1;
      end
   end
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
   parameter int EXP_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slow_tick,
   input  logic             restart,
   input  logic             en,
   input  logic [EXP_W-1:0] exp_sel,
   output logic             cnt_tick
);
   localparam int DIV_W = (1 << EXP_W) - 1;

   if (EXP_W < 1 || EXP_W > 4) begin : g_bad_exp
      $error("wdt_prescale: EXP_W must lie in 1..4");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] mask;

   // shifting out of range wraps to zero, so mask becomes all ones
   assign mask     = (DIV_W'(1) << exp_sel) - DIV_W'(1);
   assign cnt_tick = slow_tick && (!en || ((div_q & mask) == mask));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         div_q <= '0;
      else if (restart)   div_q <= '0;
      else if (slow_tick) div_q <= div_q + 1'b1;
   end
endmodule

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
   import wdt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        commit,
   input  logic [31:0] word,
   output logic        running,
   output logic        start_pulse
);
   key_state_t st_q;

   assign start_pulse = commit && (st_q == KS_RUN_ARMED) && (word == KEY_RUN2);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= KS_IDLE;
         running <= 1'b0;
      end else if (commit) begin
         st_q <= KS_IDLE;
         unique case (st_q)
            KS_IDLE: begin
               if (word == KEY_RUN1)       st_q <= KS_RUN_ARMED;
               else if (word == KEY_HALT1) st_q <= KS_HALT_ARMED;
            end
            KS_RUN_ARMED:  if (word == KEY_RUN2)  running <= 1'b1;
            KS_HALT_ARMED: if (word == KEY_HALT2) running <= 1'b0;
            default: st_q <= KS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
   import wdt_pkg::*;
#(
   parameter int          EXP_W      = 3,
   parameter int          PEND_TICKS = 2,
   parameter logic [31:0] REVISION   = 32'h0000_0031
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        slow_tick,
   input  logic        we,
   input  logic [7:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   output logic        rst_req
);
   localparam int DW = 32;
   localparam logic [7:0] SLOT_ADDR [N_SLOTS] = '{A_CTRL, A_LOAD, A_TRIG, A_KEY};

   if (EXP_W != 3) begin : g_bad_field
      $error("keyed_wdt: control layout needs a 3-bit exponent");
   end

   logic [N_SLOTS-1:0] busy;
   logic [N_SLOTS-1:0] commit;
   logic [DW-1:0]      cdata [N_SLOTS];

   for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
      wdt_posted #(.DW(DW), .PEND_TICKS(PEND_TICKS)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .slow_tick (slow_tick),
         .wr        (we && (addr == SLOT_ADDR[g])),
         .wdata     (wdata),
         .busy      (busy[g]),
         .commit    (commit[g]),
         .cdata     (cdata[g])
      );
   end

   logic [4:0]       wpend_w;
   logic             pre_en_q;
   logic [EXP_W-1:0] pre_exp_q;
   logic             sys_idle_q;
   logic [DW-1:0]    load_q, trig_q, counter_q;
   logic             running, start_pulse, cnt_tick;

   assign wpend_w = {busy[S_KEY], busy[S_TRIG], busy[S_LOAD], 1'b0, busy[S_CTRL]};

   wdt_keyseq u_keys (
      .clk         (clk),
      .rst_n       (rst_n),
      .commit      (commit[S_KEY]),
      .word        (cdata[S_KEY]),
      .running     (running),
      .start_pulse (start_pulse)
   );

   wdt_prescale #(.EXP_W(EXP_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .slow_tick (slow_tick),
      .restart   (commit[S_CTRL] || start_pulse),
      .en        (pre_en_q),
      .exp_sel   (pre_exp_q),
      .cnt_tick  (cnt_tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_en_q   <= 1'b0;
         pre_exp_q  <= '0;
         sys_idle_q <= 1'b0;
         load_q     <= '0;
      end else begin
         if (we && addr == A_SYS) sys_idle_q <= wdata[0];
         if (commit[S_CTRL]) begin
            pre_en_q  <= cdata[S_CTRL][5];
            pre_exp_q <= cdata[S_CTRL][4:2];
         end
         if (commit[S_LOAD]) load_q <= cdata[S_LOAD];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         counter_q <= '0;
         trig_q    <= '0;
         rst_req   <= 1'b0;
      end else begin
         rst_req <= 1'b0;
         if (commit[S_TRIG] && cdata[S_TRIG] != trig_q) begin
            counter_q <= load_q;
            trig_q    <= cdata[S_TRIG];
         end else if (cnt_tick && running) begin
            if (&counter_q) begin
               counter_q <= load_q;
               rst_req   <= 1'b1;
            end else begin
               counter_q <= counter_q + 1'b1;
            end
         end
      end
   end

   always_comb begin
      unique case (addr)
         A_REV:   rdata = REVISION;
         A_SYS:   rdata = {31'd0, sys_idle_q};
         A_STAT:  rdata = 32'd1;
         A_CTRL:  rdata = {26'd0, pre_en_q, pre_exp_q, 2'b00};
         A_CNT:   rdata = counter_q;
         A_LOAD:  rdata = load_q;
         A_TRIG:  rdata = trig_q;
         A_PEND:  rdata = {27'd0, wpend_w};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        slow_tick,
   input logic        we,
   input logic [7:0]  addr,
   input logic        rst_req,
   input logic [4:0]  wpend,
   input logic [31:0] counter,
   input logic        running
);
   p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   p_reset_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(running));

   p_hold_without_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !slow_tick |=> $stable(counter));

   p_load_pend_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == 8'h2C && !wpend[2]) |=> wpend[2]);

   p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wpend[2] && !slow_tick) |=> wpend[2]);

   p_start_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(running) |-> $past(slow_tick));
endmodule

bind keyed_wdt wdt_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slow_tick (slow_tick),
   .we        (we),
   .addr      (addr),
   .rst_req   (rst_req),
   .wpend     (wpend_w),
   .counter   (counter_q),
   .running   (running)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        slow_tick = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        rst_req;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   keyed_wdt i_keyed_wdt (
      .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .we(we),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      slow_tick = 1'b1;
      @(negedge clk);
      slow_tick = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic post(input logic [7:0] a, input logic [31:0] d);
      wr(a, d);
      ticks(2);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [7:0] a, input logic [31:0] e);
      logic [31:0] v;
      rd(a, v);
      check(tag, v, e);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state, R2 fixed registers
      expect_reg("R1 counter", 8'h28, 32'd0);
      expect_reg("R1 pending", 8'h34, 32'd0);
      expect_reg("R1 autoidle", 8'h10, 32'd0);
      expect_reg("R1 trigger", 8'h30, 32'd0);
      check("R1 rst_req", {31'd0, rst_req}, 32'd0);
      expect_reg("R2 revision", 8'h00, 32'h0000_0031);
      expect_reg("R2 status", 8'h14, 32'd1);
      wr(8'h10, 32'hFFFF_FFFF);
      expect_reg("R2 autoidle readback", 8'h10, 32'd1);

      // R3 posted load write
      wr(8'h2C, 32'd100);
      expect_reg("R3 load pending bit2", 8'h34, 32'h04);
      tick();
      expect_reg("R3 still pending", 8'h34, 32'h04);
      expect_reg("R3 load not yet applied", 8'h2C, 32'd0);
      tick();
      expect_reg("R3 pending cleared", 8'h34, 32'h00);
      expect_reg("R3 load applied", 8'h2C, 32'd100);

      // R8 trigger reload
      wr(8'h30, 32'd1);
      expect_reg("R3 trigger pending bit3", 8'h34, 32'h08);
      ticks(2);
      expect_reg("R8 reload on new word", 8'h28, 32'd100);
      post(8'h2C, 32'd200);
      post(8'h30, 32'd1);
      expect_reg("R8 equal word ignored", 8'h28, 32'd100);
      post(8'h30, 32'hFFFF_FFFE);
      expect_reg("R8 complement reloads", 8'h28, 32'd200);
      tick();
      expect_reg("R9 stopped holds", 8'h28, 32'd200);

      // R5 start
      wr(8'h48, 32'h0000_BBBB);
      expect_reg("R3 key pending bit4", 8'h34, 32'h10);
      ticks(2);
      post(8'h48, 32'h0000_4444);
      expect_reg("R5 start edge does not count", 8'h28, 32'd200);
      ticks(3);
      expect_reg("R9 counts while running", 8'h28, 32'd203);

      // R7 broken stop sequence keeps running
      post(8'h48, 32'h0000_AAAA);
      post(8'h48, 32'h0000_1234);
      post(8'h48, 32'h0000_5555);
      tick();
      expect_reg("R7 bad stop leaves timer running", 8'h28, 32'd210);

      // R6 stop
      post(8'h48, 32'h0000_AAAA);
      post(8'h48, 32'h0000_5555);
      expect_reg("R6 counted up to stop edge", 8'h28, 32'd214);
      tick();
      expect_reg("R6 stopped", 8'h28, 32'd214);

      // R7 broken start sequence keeps stopped
      post(8'h48, 32'h0000_BBBB);
      post(8'h48, 32'h0000_1234);
      post(8'h48, 32'h0000_4444);
      tick();
      expect_reg("R7 bad start leaves timer stopped", 8'h28, 32'd214);

      // R4 write into busy slot dropped
      wr(8'h2C, 32'd300);
      wr(8'h2C, 32'd400);
      expect_reg("R4 pending during second write", 8'h34, 32'h04);
      ticks(2);
      post(8'h30, 32'd7);
      expect_reg("R4 first write kept", 8'h28, 32'd300);

      // R11 overflow
      post(8'h2C, 32'hFFFF_FFFD);
      post(8'h30, 32'd5);
      post(8'h48, 32'h0000_BBBB);
      post(8'h48, 32'h0000_4444);
      tick();
      tick();
      expect_reg("R11 at all ones", 8'h28, 32'hFFFF_FFFF);
      check("R11 no request before wrap", {31'd0, rst_req}, 32'd0);
      tick();
      check("R11 request on wrap", {31'd0, rst_req}, 32'd1);
      expect_reg("R11 reload on wrap", 8'h28, 32'hFFFF_FFFD);
      @(negedge clk);
      check("R11 request one cycle", {31'd0, rst_req}, 32'd0);
      post(8'h48, 32'h0000_AAAA);
      post(8'h48, 32'h0000_5555);
      expect_reg("R11 stopped after second wrap", 8'h28, 32'hFFFF_FFFE);
      post(8'h2C, 32'hFFFF_FFFF);
      post(8'h30, 32'd9);
      for (int i = 0; i < 3; i++) begin
         tick();
         check("R11 no request while stopped", {31'd0, rst_req}, 32'd0);
      end
      expect_reg("R11 stopped at all ones", 8'h28, 32'hFFFF_FFFF);

      // R10 prescaler divide by 4
      wr(8'h24, 32'h0000_0028);
      expect_reg("R3 control pending bit0", 8'h34, 32'h01);
      ticks(2);
      expect_reg("R2 control readback", 8'h24, 32'h0000_0028);
      post(8'h2C, 32'd10);
      post(8'h30, 32'd6);
      post(8'h48, 32'h0000_BBBB);
      post(8'h48, 32'h0000_4444);
      ticks(3);
      expect_reg("R10 no count before 4th tick", 8'h28, 32'd10);
      tick();
      expect_reg("R10 count on 4th tick", 8'h28, 32'd11);
      ticks(4);
      expect_reg("R10 count on 8th tick", 8'h28, 32'd12);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule